// File: doc/BRIEF.md
# Truncated LLR Vector Adder-Subtractor

This block combines two truncated message vectors of a non-binary LDPC decoder node. Each vector holds N entries. An entry pairs a finite field element with an unsigned LLR, and each vector is sorted by increasing LLR. The two vectors are not aligned by position, so the block pairs entries whose field elements are equal. It adds the two LLRs of each pair, or subtracts the column LLR from the row LLR. An entry that has no partner is combined with a compensation LLR, which is the largest LLR of the other vector (its last entry). Each result goes into an insertion sorter. The sorter keeps the N smallest results in increasing order, and each kept result carries its field element.

The row vector is read through an indexed read port. The block drives `row_rd_idx` and samples `row_gf`/`row_llr` combinationally in the same cycle. The column vector is presented in parallel, because every row entry is searched against all column entries in one cycle. Both vectors must stay stable from `start` until `done`.

A four-state sequencer controls the operation:
- IDLE waits for `start`.
- IDLE→ROW_SCAN happens on `start`. This transition clears the sorter and the match flags and latches `sub_mode`.
- ROW_SCAN runs N cycles, one row entry per cycle. On the last count it moves ROW_SCAN→COL_SCAN.
- COL_SCAN runs N cycles, one column entry per cycle. On the last count it moves COL_SCAN→DONE.
- DONE lasts one cycle and raises `done`. DONE→IDLE is unconditional.

Top module: `llr_vec_addsub`

## Requirements
- R1: After reset, `done` is 0 and `out_valid` is all zeros.
- R2: `start` is accepted only in IDLE. Acceptance clears the sorter and all match flags and latches `sub_mode` for the whole operation. `start` asserted while an operation runs has no effect on that operation's result.
- R3: In the k-th cycle after the accepting edge (k = 1..N), `row_rd_idx` equals k-1.
- R4: When a row entry's field element equals that of column entry j (lowest j on duplicates), the result is row+col if `sub_mode`=0, or row−col if `sub_mode`=1. Column entry j is then flagged.
- R5: A row entry with no matching column field element is combined with column entry N-1's LLR.
- R6: In the column round, each unflagged column entry j produces (row LLR N-1) ± (col LLR j). For subtraction the row term is the minuend.
- R7: Flagged column entries produce no result, and the sorter is unchanged in those cycles.
- R8: The sorter holds at most N results in slots 0..N-1 in non-decreasing LLR order. The valid slots form a prefix. Equal LLRs keep their arrival order. A result not strictly below a full sorter's last slot is dropped.
- R9: Each output slot carries the field element of the entry that produced it: the row element in the row round, and the column element in the column round.
- R10: `done` is 1 for exactly one cycle, the (2N+1)-th cycle after the accepting edge. The output vector stays unchanged from then until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE) |
| sub_mode | input | 1 | 0 = add, 1 = row minus column |
| row_rd_idx | output | IDX_W | Row vector read index |
| row_gf | input | GF_W | Field element of the addressed row entry |
| row_llr | input | LLR_W | LLR of the addressed row entry |
| col_gf_flat | input | N*GF_W | Column field elements, entry j at bits j*GF_W |
| col_llr_flat | input | N*LLR_W | Column LLRs, entry j at bits j*LLR_W |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | N | Slot occupied flags |
| out_gf_flat | output | N*GF_W | Field element of each sorted slot |
| out_llr_flat | output | N*RES_W | Signed result LLR of each sorted slot (RES_W = LLR_W+2) |

## Verification
Two situations are hard to reach from the ports:
- A full sorter that receives a result equal to or above its last slot. Vectors with disjoint field sets create this: they yield 2N results, N of which must be dropped.
- Ties in the sorter. All-equal LLR vectors in subtract mode produce zero differences, which exercises the stable-order rule.

A `start` pulse with the opposite mode is injected in the middle of a scan to show that it is ignored. Consecutive operations with different match patterns expose flags that were not cleared.

// File: rtl/llr_vec_pkg.sv
package llr_vec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW_SCAN,
        ST_COL_SCAN,
        ST_DONE
    } phase_t;

endpackage

// File: rtl/llr_vec_match.sv
module llr_vec_match #(
    parameter int N     = 4,
    parameter int GF_W  = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [GF_W-1:0]   key_gf,
    input  logic [N*GF_W-1:0] cand_gf_flat,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [N-1:0] eq_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign eq_vec[g] = (cand_gf_flat[g*GF_W +: GF_W] == key_gf);
        end
    endgenerate

    // lowest matching index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/llr_vec_sorter.sv
module llr_vec_sorter #(
    parameter int N     = 4,
    parameter int GF_W  = 4,
    parameter int RES_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    ins_en,
    input  logic signed [RES_W-1:0] ins_llr,
    input  logic [GF_W-1:0]         ins_gf,
    output logic [N-1:0]            slot_valid,
    output logic [N*GF_W-1:0]       slot_gf_flat,
    output logic [N*RES_W-1:0]      slot_llr_flat
);

    logic signed [RES_W-1:0] llr_q [N];
    logic [GF_W-1:0]         gf_q  [N];
    logic [N-1:0]            valid_q;
    logic [N-1:0]            below;   // new value goes at or before this slot

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            logic take_new;
            logic take_prev;

            assign below[g] = !valid_q[g] || (ins_llr < llr_q[g]);

            if (g == 0) begin : g_head
                assign take_new  = below[0];
                assign take_prev = 1'b0;
            end else begin : g_tail
                assign take_new  = below[g] && !below[g-1];
                assign take_prev = below[g-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[g] <= 1'b0;
                    llr_q[g]   <= '0;
                    gf_q[g]    <= '0;
                end else if (clear) begin
                    valid_q[g] <= 1'b0;
                end else if (ins_en) begin
                    if (take_new) begin
                        valid_q[g] <= 1'b1;
                        llr_q[g]   <= ins_llr;
                        gf_q[g]    <= ins_gf;
                    end else if (take_prev) begin
                        if (g > 0) begin
                            valid_q[g] <= valid_q[(g > 0) ? g-1 : 0];
                            llr_q[g]   <= llr_q[(g > 0) ? g-1 : 0];
                            gf_q[g]    <= gf_q[(g > 0) ? g-1 : 0];
                        end
                    end
                end
            end

            assign slot_valid[g]                  = valid_q[g];
            assign slot_gf_flat[g*GF_W +: GF_W]   = gf_q[g];
            assign slot_llr_flat[g*RES_W +: RES_W] = llr_q[g];

            if (g < N - 1) begin : g_order_chk
                assert_sorted_prefix_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    valid_q[g+1] |-> (valid_q[g] && (llr_q[g] <= llr_q[g+1])));
            end
        end
    endgenerate

    assert_head_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !clear && valid_q[0] && (ins_llr < llr_q[0]))
        |=> (llr_q[0] == $past(ins_llr)));

endmodule

// File: rtl/llr_vec_addsub.sv
module llr_vec_addsub
    import llr_vec_pkg::*;
#(
    parameter int N     = 4,
    parameter int GF_W  = 4,
    parameter int LLR_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int RES_W = LLR_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sub_mode,
    output logic [IDX_W-1:0]     row_rd_idx,
    input  logic [GF_W-1:0]      row_gf,
    input  logic [LLR_W-1:0]     row_llr,
    input  logic [N*GF_W-1:0]    col_gf_flat,
    input  logic [N*LLR_W-1:0]   col_llr_flat,
    output logic                 done,
    output logic [N-1:0]         out_valid,
    output logic [N*GF_W-1:0]    out_gf_flat,
    output logic [N*RES_W-1:0]   out_llr_flat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    phase_t               state_q, state_d;
    logic [IDX_W-1:0]     cnt_q;
    logic                 sub_q;
    logic [N-1:0]         flags_q;
    logic [LLR_W-1:0]     row_comp_q;

    logic                 accept;
    logic                 last;
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic [LLR_W-1:0]     opnd_a, opnd_b;
    logic signed [RES_W-1:0] res;
    logic                 ins_en;
    logic [GF_W-1:0]      ins_gf;

    assign accept = (state_q == ST_IDLE) && start;
    assign last   = (cnt_q == LAST_IDX);

    llr_vec_match #(.N(N), .GF_W(GF_W)) u_match (
        .key_gf       (row_gf),
        .cand_gf_flat (col_gf_flat),
        .hit          (hit),
        .hit_idx      (hit_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_ROW_SCAN;
            ST_ROW_SCAN: if (last)  state_d = ST_COL_SCAN;
            ST_COL_SCAN: if (last)  state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register and round bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            sub_q      <= 1'b0;
            flags_q    <= '0;
            row_comp_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q   <= '0;
                sub_q   <= sub_mode;
                flags_q <= '0;
            end else if (state_q == ST_ROW_SCAN || state_q == ST_COL_SCAN) begin
                cnt_q <= last ? '0 : cnt_q + 1'b1;
                if (state_q == ST_ROW_SCAN) begin
                    if (hit) flags_q[hit_idx] <= 1'b1;
                    if (last) row_comp_q <= row_llr;
                end
            end
        end
    end

    // outputs and datapath
    always_comb begin
        done       = (state_q == ST_DONE);
        row_rd_idx = cnt_q;
        opnd_a     = '0;
        opnd_b     = '0;
        ins_en     = 1'b0;
        ins_gf     = '0;
        unique case (state_q)
            ST_ROW_SCAN: begin
                opnd_a = row_llr;
                opnd_b = hit ? col_llr_flat[hit_idx*LLR_W +: LLR_W]
                             : col_llr_flat[(N-1)*LLR_W +: LLR_W];
                ins_en = 1'b1;
                ins_gf = row_gf;
            end
            ST_COL_SCAN: begin
                opnd_a = row_comp_q;
                opnd_b = col_llr_flat[cnt_q*LLR_W +: LLR_W];
                ins_en = !flags_q[cnt_q];
                ins_gf = col_gf_flat[cnt_q*GF_W +: GF_W];
            end
            default: ;
        endcase
        res = sub_q ? (signed'({2'b00, opnd_a}) - signed'({2'b00, opnd_b}))
                    : (signed'({2'b00, opnd_a}) + signed'({2'b00, opnd_b}));
    end

    llr_vec_sorter #(.N(N), .GF_W(GF_W), .RES_W(RES_W)) u_sorter (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (accept),
        .ins_en        (ins_en),
        .ins_llr       (res),
        .ins_gf        (ins_gf),
        .slot_valid    (out_valid),
        .slot_gf_flat  (out_gf_flat),
        .slot_llr_flat (out_llr_flat)
    );

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid == '0 && flags_q == '0 && sub_q == $past(sub_mode)));

    assert_row_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW_SCAN && !last) |=> (row_rd_idx == $past(row_rd_idx) + 1'b1));

    assert_flagged_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COL_SCAN && flags_q[cnt_q])
        |=> ($stable(out_valid) && $stable(out_llr_flat) && $stable(out_gf_flat)));

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(sub_q));

endmodule

// File: tb/llr_vec_addsub_test.sv
module llr_vec_addsub_test;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int GF_W  = 4;
    localparam int LLR_W = 8;
    localparam int IDX_W = $clog2(N);
    localparam int RES_W = LLR_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sub_mode = 1'b0;
    logic [IDX_W-1:0]   row_rd_idx;
    logic [GF_W-1:0]    row_gf;
    logic [LLR_W-1:0]   row_llr;
    logic [N*GF_W-1:0]  col_gf_flat;
    logic [N*LLR_W-1:0] col_llr_flat;
    logic               done;
    logic [N-1:0]       out_valid;
    logic [N*GF_W-1:0]  out_gf_flat;
    logic [N*RES_W-1:0] out_llr_flat;

    logic [GF_W-1:0]  rgf  [N];
    logic [LLR_W-1:0] rllr [N];
    logic [GF_W-1:0]  cgf  [N];
    logic [LLR_W-1:0] cllr [N];

    int n_cmp = 0;
    int n_bad = 0;
    int exp_llr[$];
    int exp_gf[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        row_gf  = rgf[row_rd_idx];
        row_llr = rllr[row_rd_idx];
        for (int j = 0; j < N; j++) begin
            col_gf_flat[j*GF_W +: GF_W]    = cgf[j];
            col_llr_flat[j*LLR_W +: LLR_W] = cllr[j];
        end
    end

    llr_vec_addsub #(.N(N), .GF_W(GF_W), .LLR_W(LLR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
        .row_rd_idx(row_rd_idx), .row_gf(row_gf), .row_llr(row_llr),
        .col_gf_flat(col_gf_flat), .col_llr_flat(col_llr_flat),
        .done(done), .out_valid(out_valid), .out_gf_flat(out_gf_flat),
        .out_llr_flat(out_llr_flat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // stable insertion keeping the N smallest
    task automatic model_insert(input int v, input int g);
        int p = exp_llr.size();
        for (int i = exp_llr.size() - 1; i >= 0; i--)
            if (v < exp_llr[i]) p = i;
        exp_llr.insert(p, v);
        exp_gf.insert(p, g);
        if (exp_llr.size() > N) begin
            void'(exp_llr.pop_back());
            void'(exp_gf.pop_back());
        end
    endtask

    task automatic build_expect(input bit sb);
        bit fl[N];
        exp_llr.delete();
        exp_gf.delete();
        for (int j = 0; j < N; j++) fl[j] = 1'b0;
        for (int i = 0; i < N; i++) begin
            int b = int'(cllr[N-1]);
            for (int j = N - 1; j >= 0; j--)
                if (cgf[j] == rgf[i]) b = int'(cllr[j]);
            for (int j = 0; j < N; j++)
                if (cgf[j] == rgf[i]) begin fl[j] = 1'b1; break; end
            model_insert(sb ? int'(rllr[i]) - b : int'(rllr[i]) + b, int'(rgf[i]));
        end
        for (int j = 0; j < N; j++)
            if (!fl[j])
                model_insert(sb ? int'(rllr[N-1]) - int'(cllr[j])
                                : int'(rllr[N-1]) + int'(cllr[j]), int'(cgf[j]));
    endtask

    task automatic gen(input int kind);
        int acc_r = $urandom_range(0, 30);
        int acc_c = $urandom_range(0, 30);
        for (int i = 0; i < N; i++) begin
            acc_r += $urandom_range(0, 50);
            acc_c += $urandom_range(0, 50);
            rllr[i] = (kind == 3) ? LLR_W'(10) : LLR_W'(acc_r);
            cllr[i] = (kind == 3) ? LLR_W'(10) : LLR_W'(acc_c);
            case (kind)
                0: rgf[i] = GF_W'((i * 5 + 3) % 16);
                1: rgf[i] = GF_W'(i);
                default: rgf[i] = GF_W'(i);
            endcase
        end
        for (int j = 0; j < N; j++) begin
            case (kind)
                0: cgf[j] = rgf[(j + 1) % N];
                1: cgf[j] = GF_W'(8 + j);
                default: cgf[j] = (j % 2 == 0) ? GF_W'(N - 1 - j) : GF_W'(8 + j);
            endcase
        end
    endtask

    task automatic check_outputs(input string tag);
        for (int i = 0; i < N; i++) begin
            bit ev = (i < exp_llr.size());
            check(out_valid[i] == ev, {"R8 slot valid ", tag}, int'(out_valid[i]), int'(ev));
            if (ev) begin
                int al = int'($signed(out_llr_flat[i*RES_W +: RES_W]));
                int ag = int'(out_gf_flat[i*GF_W +: GF_W]);
                check(al == exp_llr[i], {"R4 R5 R6 R8 slot llr ", tag}, al, exp_llr[i]);
                check(ag == exp_gf[i], {"R9 slot gf ", tag}, ag, exp_gf[i]);
            end
        end
    endtask

    task automatic run_op(input int kind, input bit sb, input bit poke, input string tag);
        gen(kind);
        build_expect(sb);
        @(negedge clk);
        start = 1'b1;
        sub_mode = sb;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= 2 * N + 2; k++) begin
            if (k > 1) @(negedge clk);
            check(done == (k == 2 * N + 1), {"R10 done timing ", tag}, int'(done), int'(k == 2 * N + 1));
            if (k <= N)
                check(int'(row_rd_idx) == k - 1, {"R3 row index ", tag}, int'(row_rd_idx), k - 1);
            if (k >= 2 * N + 1)
                check_outputs(tag);
            if (poke && k == 3) begin
                start = 1'b1;      // R2: must be ignored mid-run
                sub_mode = ~sb;
            end else begin
                start = 1'b0;
                sub_mode = sb;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            rgf[i] = '0; rllr[i] = '0; cgf[i] = '0; cllr[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(out_valid == '0, "R1 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        run_op(0, 1'b0, 1'b0, "full match add");
        run_op(0, 1'b1, 1'b0, "full match sub");
        run_op(1, 1'b0, 1'b0, "disjoint add R5 R6");
        run_op(1, 1'b1, 1'b0, "disjoint sub");
        run_op(2, 1'b0, 1'b0, "partial add R7");
        run_op(2, 1'b1, 1'b1, "partial sub R2 poke");
        run_op(3, 1'b1, 1'b0, "ties sub");
        run_op(3, 1'b0, 1'b1, "ties add R2 poke");
        for (int r = 0; r < 6; r++)
            run_op(r % 3, r[0], r == 4, "random");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule